// File: doc/BRIEF.md
# Right-justified stereo serial audio receiver

This block takes a three-wire stereo serial audio stream (bit clock, word clock and serial data) and turns it into parallel 16-bit two's-complement samples, one per channel. Both lines are sampled on the rising bit-clock edge. The transmitter moves them on the falling edge, so each sample is taken in the middle of a bit. Each word is right-justified: the valid 16 bits are the last ones before the word clock changes level. Any bits earlier in a longer slot are padding and are dropped.

The block runs entirely on a fast system clock. It passes the three serial lines through synchronisers and finds bit-clock edges in the system-clock domain. It needs no setting to tell 48 from 64 bit clocks per sample period. Once both the left word and the right word of a frame are captured, it shows the pair on its outputs with a one-cycle valid pulse. One shared flag reports a run of stereo frames in which both words were all zero.

Top module: `rj_audio_rx`

## Requirements
- R1: Serial data and word clock are sampled on rising bit-clock edges, after synchronisation to the system clock. Words arrive MSB first, and the LSB is the last bit before the word-clock level change.
- R2: The word for a channel is exactly the 16 bits received just before the word-clock transition that ends its slot. All earlier bits in the slot are ignored, whatever their value.
- R3: Slots of 24 bits (48 bit clocks per sample period) and of 32 bits (64 per period) are both decoded correctly. The two rates may be mixed from frame to frame, with no configuration.
- R4: With the default polarity, word clock high marks the left slot and low marks the right slot, and left comes first in each frame. After the right word is captured, `smp_valid_o` pulses high for exactly one system-clock cycle. `smp_left_o` and `smp_right_o` change only in that cycle and hold their values in between.
- R5: A slot that held fewer than 16 bits before its closing transition (for example the first one after reset) is never presented. Each full left/right pair gives exactly one valid pulse.
- R6: `zero_flag_o` goes high after ZERO_FRAMES presented frames in a row (default 2048) have both words equal to 0x0000. It stays high while all-zero frames continue.
- R7: `zero_flag_o` goes low after the first presented frame that has any nonzero bit in either word. The zero-frame run count then starts again from zero.
- R8: While reset is active and right after it, `smp_valid_o`, `smp_left_o`, `smp_right_o` and `zero_flag_o` are all 0, and the zero-run count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bclk | input | 1 | Serial bit clock (asynchronous) |
| ser_wclk | input | 1 | Word clock; its level selects the channel |
| ser_data | input | 1 | Serial data, MSB first, right-justified |
| smp_left_o | output | 16 | Left-channel sample, two's complement |
| smp_right_o | output | 16 | Right-channel sample, two's complement |
| smp_valid_o | output | 1 | One-cycle strobe when a new sample pair is presented |
| zero_flag_o | output | 1 | High after a run of all-zero stereo frames |

## Verification
The bench fills the padding bits with ones and sends words whose MSB and LSB differ, such as 0x8000, 0x7FFF and 0x0001. A receiver that keeps the first 16 bits, or that is off by one bit position, therefore returns visibly wrong words. It mixes 24-bit and 32-bit slots from one frame to the next, which exposes any built-in assumption about slot length. After reset it sends a truncated slot, which catches a design that presents a partial word or pulses valid too often. The zero-flag checks cover a run one frame short of the limit, the exact limit, and the first nonzero frame, including a nonzero value only in the right LSB. They also check that reset clears a partial run, so a design that counts wrongly, never clears, or keeps its count across reset disagrees.

// File: rtl/rjrx_pkg.sv
package rjrx_pkg;
   // channel selected by the registered word-clock level
   typedef enum logic {
      CH_RIGHT = 1'b0,
      CH_LEFT  = 1'b1
   } rjrx_chan_e;

   // index of each serial line inside the synchroniser bundle
   localparam int unsigned SIG_BCLK = 0;
   localparam int unsigned SIG_WCLK = 1;
   localparam int unsigned SIG_DATA = 2;
   localparam int unsigned SIG_CNT  = 3;
endpackage

// File: rtl/rjrx_sync.sv
module rjrx_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rjrx_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rjrx_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rjrx_framer.sv
module rjrx_framer
   import rjrx_pkg::*;
#(
   parameter int unsigned WORD_W    = 16,
   parameter bit          LEFT_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb_i,
   input  logic              wclk_i,
   input  logic              sdat_i,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o
);
   localparam int unsigned CW = $clog2(WORD_W + 1);
   localparam logic [CW-1:0] FULL = CW'(WORD_W);

   if (WORD_W < 2) begin : g_bad_word
      $error("rjrx_framer: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] shreg_q, left_hold_q, left_q, right_q;
   logic [CW-1:0]     cnt_q;
   logic              primed_q, wclk_prev_q, left_ok_q, valid_q;
   rjrx_chan_e        prev_chan;

   // polarity variant chosen at elaboration
   if (LEFT_HIGH) begin : g_pol_high
      assign prev_chan = wclk_prev_q ? CH_LEFT : CH_RIGHT;
   end else begin : g_pol_low
      assign prev_chan = wclk_prev_q ? CH_RIGHT : CH_LEFT;
   end

   logic [WORD_W-1:0] shreg_nx;
   assign shreg_nx = {shreg_q[WORD_W-2:0], sdat_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q     <= '0;
         left_hold_q <= '0;
         left_q      <= '0;
         right_q     <= '0;
         cnt_q       <= '0;
         primed_q    <= 1'b0;
         wclk_prev_q <= 1'b0;
         left_ok_q   <= 1'b0;
         valid_q     <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (bit_stb_i) begin
            shreg_q <= shreg_nx;
            if (!primed_q) begin
               primed_q    <= 1'b1;
               wclk_prev_q <= wclk_i;
               cnt_q       <= CW'(1);
            end else if (wclk_i != wclk_prev_q) begin
               // slot closed: the register holds its last WORD_W bits
               wclk_prev_q <= wclk_i;
               cnt_q       <= CW'(1);
               if (cnt_q == FULL) begin
                  if (prev_chan == CH_LEFT) begin
                     left_hold_q <= shreg_q;
                     left_ok_q   <= 1'b1;
                  end else if (left_ok_q) begin
                     left_q    <= left_hold_q;
                     right_q   <= shreg_q;
                     valid_q   <= 1'b1;
                     left_ok_q <= 1'b0;
                  end
               end else begin
                  left_ok_q <= 1'b0;
               end
            end else if (cnt_q != FULL) begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

   assign left_o  = left_q;
   assign right_o = right_q;
   assign valid_o = valid_q;

   // R4: strobe lasts a single system-clock cycle
   a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   // R4: outputs hold between strobes
   a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));
   // R1: a new pair only follows a sampled bit-clock rising edge
   a_r1_on_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(bit_stb_i));
endmodule

// File: rtl/rjrx_zero_mon.sv
module rjrx_zero_mon #(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned ZERO_FRAMES = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb_i,
   input  logic [WORD_W-1:0] left_i,
   input  logic [WORD_W-1:0] right_i,
   output logic              zero_o
);
   localparam int unsigned ZCW = $clog2(ZERO_FRAMES + 1);
   localparam logic [ZCW-1:0] LIMIT = ZCW'(ZERO_FRAMES);

   if (ZERO_FRAMES < 1) begin : g_bad_limit
      $error("rjrx_zero_mon: ZERO_FRAMES must be at least 1");
   end

   logic [ZCW-1:0] run_q;
   logic           any_one;
   assign any_one = (|left_i) | (|right_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (frame_stb_i) begin
         if (any_one)            run_q <= '0;
         else if (run_q != LIMIT) run_q <= run_q + ZCW'(1);
      end
   end

   assign zero_o = (run_q == LIMIT);

   // R7: any nonzero bit in a frame drops the flag
   a_r7_clear_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb_i && any_one) |=> !zero_o);
   // R6: the flag only rises right after a presented frame
   a_r6_rise_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(zero_o) |-> $past(frame_stb_i));
endmodule

// File: rtl/rj_audio_rx.sv
module rj_audio_rx
   import rjrx_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ZERO_FRAMES = 2048,
   parameter bit          LEFT_HIGH   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bclk,
   input  logic              ser_wclk,
   input  logic              ser_data,
   output logic [WORD_W-1:0] smp_left_o,
   output logic [WORD_W-1:0] smp_right_o,
   output logic              smp_valid_o,
   output logic              zero_flag_o
);
   logic [SIG_CNT-1:0] raw, synced;
   logic               bclk_d_q, bit_stb;

   assign raw[SIG_BCLK] = ser_bclk;
   assign raw[SIG_WCLK] = ser_wclk;
   assign raw[SIG_DATA] = ser_data;

   rjrx_sync #(.WIDTH(SIG_CNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(synced));

   always_ff @(posedge clk) begin
      if (!rst_n) bclk_d_q <= 1'b0;
      else        bclk_d_q <= synced[SIG_BCLK];
   end
   assign bit_stb = synced[SIG_BCLK] & ~bclk_d_q;

   rjrx_framer #(.WORD_W(WORD_W), .LEFT_HIGH(LEFT_HIGH)) u_framer (
      .clk(clk), .rst_n(rst_n), .bit_stb_i(bit_stb),
      .wclk_i(synced[SIG_WCLK]), .sdat_i(synced[SIG_DATA]),
      .left_o(smp_left_o), .right_o(smp_right_o), .valid_o(smp_valid_o));

   rjrx_zero_mon #(.WORD_W(WORD_W), .ZERO_FRAMES(ZERO_FRAMES)) u_zero (
      .clk(clk), .rst_n(rst_n), .frame_stb_i(smp_valid_o),
      .left_i(smp_left_o), .right_i(smp_right_o), .zero_o(zero_flag_o));

   // R8: nothing presented in the cycle after reset
   a_r8_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!smp_valid_o && !zero_flag_o));
   // R1: bit strobes are isolated single cycles
   a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> !bit_stb);
endmodule

// File: tb/rj_audio_rx_tb_top.sv
`timescale 1ns/1ps
module rj_audio_rx_tb_top;
   localparam int ZF = 4;
   // {rate64, left, right}
   localparam logic [32:0] VEC [10] = '{
      {1'b0, 16'h1234, 16'hABCD},
      {1'b1, 16'h8000, 16'h7FFF},
      {1'b0, 16'hFFFF, 16'h0001},
      {1'b1, 16'h0000, 16'h0000},
      {1'b1, 16'h0000, 16'h0000},
      {1'b0, 16'h0000, 16'h0000},
      {1'b1, 16'h0000, 16'h0000},
      {1'b0, 16'h0000, 16'h0000},
      {1'b1, 16'h0000, 16'h0001},
      {1'b0, 16'hA5A5, 16'h5A5A}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic bclk = 1'b0, wclk = 1'b0, sdat = 1'b0;
   logic [15:0] lo, ro;
   logic vo, zo;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rj_audio_rx #(.ZERO_FRAMES(ZF)) dut_i (
      .clk(clk), .rst_n(rst_n), .ser_bclk(bclk), .ser_wclk(wclk),
      .ser_data(sdat), .smp_left_o(lo), .smp_right_o(ro),
      .smp_valid_o(vo), .zero_flag_o(zo));

   logic [32:0] expq [$];
   int run = 0, flag_dly = 0;
   bit exp_flag = 1'b0, prev_v = 1'b0;
   logic [15:0] last_l = '0, last_r = '0;

   always @(posedge clk) begin
      #1;
      if (!rst_n) begin
         expq.delete(); run = 0; exp_flag = 1'b0; flag_dly = 0;
         prev_v = 1'b0; last_l = '0; last_r = '0;
      end else begin
         if (vo && prev_v) begin
            n_fail++; $display("FAIL R4 valid wider than one cycle: got 1 expected 0");
         end
         if (!vo && (lo != last_l || ro != last_r)) begin
            n_fail++; $display("FAIL R4 outputs moved without valid: got %h/%h expected %h/%h",
                               lo, ro, last_l, last_r);
         end
         if (vo) begin
            n_chk++;
            if (expq.size() == 0) begin
               n_fail++; $display("FAIL R5 unexpected valid: got 1 expected 0");
            end else begin
               logic [32:0] e;
               e = expq.pop_front();
               n_chk++;
               if (lo != e[31:16]) begin
                  n_fail++; $display("FAIL R1/R2/R3 left word (rate64=%0b): got %h expected %h",
                                     e[32], lo, e[31:16]);
               end
               n_chk++;
               if (ro != e[15:0]) begin
                  n_fail++; $display("FAIL R2/R3/R4 right word (rate64=%0b): got %h expected %h",
                                     e[32], ro, e[15:0]);
               end
               run = (e[31:0] == 32'h0) ? run + 1 : 0;
               exp_flag = (run >= ZF);
               flag_dly = 3;
            end
            last_l = lo; last_r = ro;
         end
         if (flag_dly > 0) begin
            flag_dly--;
            if (flag_dly == 0) begin
               n_chk++;
               if (zo != exp_flag) begin
                  n_fail++; $display("FAIL R6/R7 zero flag after run %0d: got %0b expected %0b",
                                     run, zo, exp_flag);
               end
            end
         end
         prev_v = vo;
      end
   end

   task automatic send_bit(input logic lr, input logic d);
      @(negedge clk); bclk = 1'b0; wclk = lr; sdat = d;
      repeat (8) @(negedge clk);
      bclk = 1'b1;
      repeat (7) @(negedge clk);
   endtask

   task automatic send_slot(input logic lr, input logic r64, input logic [15:0] w);
      int nb = r64 ? 32 : 24;
      for (int i = 0; i < nb - 16; i++) send_bit(lr, 1'b1);   // junk padding
      for (int i = 15; i >= 0; i--) send_bit(lr, w[i]);
   endtask

   task automatic send_frame(input logic [32:0] v);
      expq.push_back(v);
      send_slot(1'b1, v[32], v[31:16]);
      send_slot(1'b0, v[32], v[15:0]);
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1);
      repeat (20) @(negedge clk);
   endtask

   task automatic check_reset_state(input string tag);
      @(posedge clk); #1;
      n_chk++;
      if (vo !== 1'b0 || lo !== 16'h0 || ro !== 16'h0 || zo !== 1'b0) begin
         n_fail++; $display("FAIL R8 %s: got v=%b l=%h r=%h z=%b expected all 0", tag, vo, lo, ro, zo);
      end
   endtask

   task automatic check_drained(input string tag);
      n_chk++;
      if (expq.size() != 0) begin
         n_fail++; $display("FAIL R5 %s: got %0d pending frames expected 0", tag, expq.size());
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check_reset_state("during reset");
      @(negedge clk); rst_n = 1'b1;
      check_reset_state("after reset");
      // priming right slot, never presented (R5)
      send_slot(1'b0, 1'b1, 16'hFFFF);
      for (int k = 0; k < 10; k++) send_frame(VEC[k]);
      flush();
      check_drained("vector table");

      // directed: reset clears a partial zero run (R8, R6)
      send_frame(33'h0); send_frame(33'h0);
      flush();
      check_drained("pre-reset zeros");
      @(negedge clk); rst_n = 1'b0;
      check_reset_state("mid-stream reset");
      @(negedge clk); rst_n = 1'b1;
      // truncated right slot then full frames (R5)
      for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b1);
      send_frame(33'h0); send_frame({1'b1, 32'h0}); send_frame(33'h0);
      flush();
      check_drained("after truncated slot");
      n_chk++;
      if (zo !== 1'b0) begin
         n_fail++; $display("FAIL R6 run of %0d after reset: got %b expected 0", ZF - 1, zo);
      end
      // reach the limit exactly, then a lone right LSB clears it (R6, R7)
      send_frame({1'b1, 32'h0});
      send_frame({1'b0, 16'h0000, 16'h0001});
      flush();
      check_drained("limit and clear");
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_fail++; $display("FAIL watchdog: got timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule